// File: doc/BRIEF.md
# Paged SPI Switch Management Bridge

This block lets a processor reach the management port of an Ethernet switch through a handful of 8-bit registers. Software picks a page, a register inside that page and, for reads, a starting byte. For a write it loads up to eight data bytes. It then starts the operation by writing a byte count. The bridge turns the request into one or more SPI frames. It shifts the page, the register address and the data out, most significant bit first. For reads it polls the switch's status byte until the data is ready. It then collects the requested bytes into the data registers.

A status register reports whether an operation is still running and why the last one failed. The three error flags are sticky: they stay set until the next operation is started. While an operation runs, the bridge ignores every host register write, so software polls the busy flag before it touches the bridge.

Top module: `spi_switch_bridge`

## Requirements
- R1: Host register map: page 0x1A, register address 0x1B, byte offset 0x1C (3 bits, read back zero-extended), read count 0x1D, write count 0x1E, status 0x1F, data bytes 0 to 7 at 0x20 to 0x27; other offsets read 0. After reset all registers read 0, chip select is high and the SPI clock is high.
- R2: A host write of a count from 1 to 8 to 0x1E while idle sends one frame: 0x61, page, register address, then data bytes 0 up to count-1 in that order.
- R3: SPI mode 3 timing: the SPI clock is high whenever chip select is high. Bits travel most significant bit first. Output bits change while the clock is low, and input bits are taken at the rising edge. Each clock half lasts HALF_DIV cycles, and chip select stays high for at least HALF_DIV cycles between the frames of one operation.
- R4: A host write of a count from 1 to 8 to 0x1D while idle sends a request frame (0x60, page, register address). It then sends poll frames (0x60, 0xFE, one received status byte) until a received status byte has bit 0 set.
- R5: After a ready poll, a data frame 0x60, 0xF0 follows, and the bridge receives offset+count bytes. It discards the first offset bytes and stores the next count bytes into data bytes 0 onward, leaving the higher data bytes unchanged. Bytes beyond the real width of the switch register are stored as received.
- R6: Status bit 0 (busy) reads 1 from the cycle after a valid launch until the last frame of that operation has ended.
- R7: A launch count of 0 or above 8 sets status bit 3 (count error), produces no frame and leaves busy at 0.
- R8: If 16 consecutive polls return bit 0 clear, status bit 2 (acknowledge error) is set and no data frame is sent.
- R9: A polled status byte with bit 1 set ends the read at once, with status bit 1 (framing error) set.
- R10: All error flags are cleared by the next launch and are held through any other register access.
- R11: While busy, all host writes are ignored, including writes to the count registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 8 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for reg_addr (combinational) |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | SPI data to switch |
| spi_miso | input | 1 | SPI data from switch |

## Verification
The bench models the switch at the bit level and drives two kinds of read past the normal path. One kind turns ready only on the third poll. The other never turns ready, which tests the exact count of sixteen polls: an off-by-one counter would send 15 or 17 poll frames, or would send a data frame anyway. Reads with a nonzero offset and a full eight-byte count show whether the bridge skips the right bytes and indexes the data registers correctly, including the longest frame of 17 bytes. Register writes and count writes made while a read is running show whether a busy bridge ignores them. Ordinary register writes made after a failed read show whether the sticky flags are lost early. A design that cleared them on any host write, or acted on a launch while busy, would show a changed page value, a stray write frame or a spurious count error.

// File: rtl/spi_switch_bridge.sv
module spi_switch_bridge #(
  parameter int HALF_DIV  = 2,
  parameter int MAX_POLLS = 16,
  parameter int NDATA     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_cs_n,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int HW = $clog2(HALF_DIV + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int OW = $clog2(NDATA);
  localparam int BW = $clog2(2 * NDATA + 2);
  localparam logic [7:0] A_PAGE = 8'h1A, A_ADDR = 8'h1B, A_OFF = 8'h1C;
  localparam logic [7:0] A_RCNT = 8'h1D, A_WCNT = 8'h1E, A_STAT = 8'h1F, A_DATA = 8'h20;
  localparam logic [7:0] CMD_WR = 8'h61, CMD_RD = 8'h60, SW_STS = 8'hFE, SW_DATA = 8'hF0;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} state_t;
  typedef enum logic [1:0] {K_WR, K_REQ, K_POLL, K_DATA} kind_t;

  state_t state;
  kind_t  kind;
  logic [7:0] page_q, addr_q, rcnt_q, wcnt_q, tx_sh, rx_sh, tx_next;
  logic [OW-1:0] off_q;
  logic [7:0] data_q [NDATA];
  logic fr_err, ack_err, cnt_err, sck_q, cs_n_q;
  logic [BW-1:0] byte_idx, frame_len, nidx, ridx;
  logic [2:0] bit_idx;
  logic [HW-1:0] half_q;
  logic [PW-1:0] poll_q;

  wire busy     = state != S_IDLE;
  wire host_ok  = reg_wr && !busy;
  wire in_data  = reg_addr >= A_DATA && reg_addr < A_DATA + 8'(NDATA);
  wire cnt_bad  = reg_wdata == 8'd0 || reg_wdata > 8'(NDATA);
  wire half_end = half_q == HW'(HALF_DIV - 1);
  wire last_byte = byte_idx == frame_len - BW'(1);
  wire rx_keep  = kind == K_DATA && byte_idx >= BW'(2) + BW'(off_q);

  assign spi_cs_n = cs_n_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = tx_sh[7];
  assign nidx     = byte_idx + BW'(1);
  assign ridx     = byte_idx - BW'(2) - BW'(off_q);

  always_comb begin
    case (kind)
      K_WR:    frame_len = BW'(3) + BW'(wcnt_q);
      K_DATA:  frame_len = BW'(2) + BW'(off_q) + BW'(rcnt_q);
      default: frame_len = BW'(3);
    endcase
    tx_next = 8'h00;
    case (kind)
      K_WR:    tx_next = (nidx == BW'(1)) ? page_q : (nidx == BW'(2)) ? addr_q
                       : data_q[OW'(nidx - BW'(3))];
      K_REQ:   tx_next = (nidx == BW'(1)) ? page_q : (nidx == BW'(2)) ? addr_q : 8'h00;
      K_POLL:  tx_next = (nidx == BW'(1)) ? SW_STS : 8'h00;
      K_DATA:  tx_next = (nidx == BW'(1)) ? SW_DATA : 8'h00;
    endcase
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (in_data) reg_rdata = data_q[reg_addr[OW-1:0]];
    else case (reg_addr)
      A_PAGE: reg_rdata = page_q;
      A_ADDR: reg_rdata = addr_q;
      A_OFF:  reg_rdata = 8'(off_q);
      A_RCNT: reg_rdata = rcnt_q;
      A_WCNT: reg_rdata = wcnt_q;
      A_STAT: reg_rdata = {4'b0, cnt_err, ack_err, fr_err, busy};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_WR;
      page_q <= '0; addr_q <= '0; off_q <= '0; rcnt_q <= '0; wcnt_q <= '0;
      for (int i = 0; i < NDATA; i++) data_q[i] <= '0;
      fr_err <= 1'b0; ack_err <= 1'b0; cnt_err <= 1'b0;
      sck_q <= 1'b1; cs_n_q <= 1'b1; tx_sh <= '0; rx_sh <= '0;
      byte_idx <= '0; bit_idx <= '0; half_q <= '0; poll_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (host_ok) begin
          if (in_data) data_q[reg_addr[OW-1:0]] <= reg_wdata;
          case (reg_addr)
            A_PAGE: page_q <= reg_wdata;
            A_ADDR: addr_q <= reg_wdata;
            A_OFF:  off_q  <= reg_wdata[OW-1:0];
            A_RCNT, A_WCNT: begin
              if (reg_addr == A_WCNT) wcnt_q <= reg_wdata; else rcnt_q <= reg_wdata;
              fr_err <= 1'b0; ack_err <= 1'b0; cnt_err <= cnt_bad;
              if (!cnt_bad) begin
                state <= S_XFER; kind <= (reg_addr == A_WCNT) ? K_WR : K_REQ;
                tx_sh <= (reg_addr == A_WCNT) ? CMD_WR : CMD_RD;
                cs_n_q <= 1'b0; sck_q <= 1'b0;
                byte_idx <= '0; bit_idx <= '0; half_q <= '0;
              end
            end
            default: ;
          endcase
        end
        S_GAP: begin
          half_q <= half_end ? '0 : half_q + HW'(1);
          if (half_end) begin
            state <= S_XFER; tx_sh <= CMD_RD; cs_n_q <= 1'b0; sck_q <= 1'b0;
            byte_idx <= '0; bit_idx <= '0;
          end
        end
        default: begin
          half_q <= half_end ? '0 : half_q + HW'(1);
          if (half_end) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
              rx_sh <= {rx_sh[6:0], spi_miso};
            end else if (bit_idx != 3'd7) begin
              sck_q <= 1'b0; bit_idx <= bit_idx + 3'd1;
              tx_sh <= {tx_sh[6:0], 1'b0};
            end else begin
              bit_idx <= '0;
              if (rx_keep) data_q[OW'(ridx)] <= rx_sh;
              if (!last_byte) begin
                sck_q <= 1'b0; byte_idx <= nidx; tx_sh <= tx_next;
              end else begin
                cs_n_q <= 1'b1;
                case (kind)
                  K_REQ: begin kind <= K_POLL; poll_q <= PW'(1); state <= S_GAP; end
                  K_POLL:
                    if (rx_sh[1]) begin fr_err <= 1'b1; state <= S_IDLE; end
                    else if (rx_sh[0]) begin kind <= K_DATA; state <= S_GAP; end
                    else if (poll_q == PW'(MAX_POLLS)) begin ack_err <= 1'b1; state <= S_IDLE; end
                    else begin poll_q <= poll_q + PW'(1); state <= S_GAP; end
                  default: state <= S_IDLE;
                endcase
              end
            end
          end
        end
      endcase
    end
  end

  // R3
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> spi_sck);
  // R6
  busy_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !spi_cs_n |-> busy);
  // R7
  cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cnt_err) |-> spi_cs_n && !busy);
  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) poll_q <= PW'(MAX_POLLS));
  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({fr_err, ack_err, cnt_err}));
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_addr == A_PAGE |=> $stable(page_q));
endmodule

// File: tb/test_spi_switch_bridge.sv
`timescale 1ns/1ps
module test_spi_switch_bridge;
  localparam int HALF = 2;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, spi_miso = 1'b1;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  int errs = 0, checks = 0;

  spi_switch_bridge #(.HALF_DIV(HALF), .MAX_POLLS(16), .NDATA(8)) i_spi_switch_bridge (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  always #4 clk = ~clk;

  function automatic logic [7:0] swmem(int k);
    return 8'(90 + 37 * k);
  endfunction

  // behavioural switch model, updated every clock
  logic [7:0] flog [0:63][0:23];
  int flen [0:63];
  logic [7:0] cur [0:23];
  logic [7:0] rsh = 8'h00, osh = 8'hFF;
  int nfr = 0, bitc = 0, bytec = 0, gapc = 0, mode_bad = 0, gap_bad = 0, poll_seen = 0;
  int pbase = 0, ready_after = 1;
  logic frame_err = 1'b0, pcs = 1'b1, psck = 1'b1;

  always @(negedge clk) begin
    if (rst_n && spi_cs_n && !spi_sck) mode_bad++;
    if (spi_cs_n) gapc++;
    if (pcs && !spi_cs_n) begin
      if (nfr > 0 && gapc < HALF) gap_bad++;
      bytec = 0; bitc = 0; osh = 8'hFF; spi_miso = osh[7];
    end else if (!spi_cs_n) begin
      if (!psck && spi_sck) begin
        rsh = {rsh[6:0], spi_mosi}; bitc++;
        if (bitc == 8) begin
          if (bytec < 24) cur[bytec] = rsh;
          bytec++; bitc = 0;
        end
      end else if (psck && !spi_sck) begin
        if (bitc == 0) begin
          osh = 8'hFF;
          if (bytec == 2 && cur[1] == 8'hFE) begin
            poll_seen++;
            osh = frame_err ? 8'h02 : ((poll_seen - pbase) >= ready_after ? 8'h01 : 8'h00);
          end else if (bytec >= 2 && cur[1] == 8'hF0) osh = swmem(bytec - 2);
        end else osh = {osh[6:0], 1'b1};
        spi_miso = osh[7];
      end
    end
    if (!pcs && spi_cs_n) begin
      if (nfr < 64) begin
        flen[nfr] = bytec;
        for (int k = 0; k < 24; k++) flog[nfr][k] = cur[k];
      end
      nfr++; gapc = 1;
    end
    pcs = spi_cs_n; psck = spi_sck;
  end

  int fbase = 0;
  logic [7:0] expq [$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    int n = 0;
    do begin @(negedge clk); rd(8'h1F, s); n++; end while (s[0] && n < 20000);
    chk(!s[0], "R6 busy never cleared", s, 0);
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v); chk(v == e, req, v, e);
  endtask

  task automatic chk_frame(input int fi, input int explen, input string req);
    int i = fbase + fi;
    bit ok = (flen[i] == explen);
    for (int k = 0; k < expq.size(); k++) if (flog[i][k] != expq[k]) ok = 0;
    chk(ok, req, (flen[i] << 16) | (flog[i][0] << 8) | flog[i][1],
        (explen << 16) | (expq[0] << 8) | expq[1]);
  endtask

  task automatic start_read(input logic [7:0] pg, input logic [7:0] ad, input logic [7:0] off,
                            input logic [7:0] cnt, input int ready);
    fbase = nfr; pbase = poll_seen; ready_after = ready;
    wr(8'h1A, pg); wr(8'h1B, ad); wr(8'h1C, off); wr(8'h1D, cnt);
  endtask

  initial begin
    logic [7:0] v;
    bit seen_wr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n && spi_sck, "R1 SPI idle after reset", {spi_cs_n, spi_sck}, 3);
    expect_reg(8'h1F, 8'h00, "R1 status reset");
    expect_reg(8'h1A, 8'h00, "R1 page reset");
    expect_reg(8'h27, 8'h00, "R1 data7 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 offset field width and map
    wr(8'h1C, 8'hFD);
    expect_reg(8'h1C, 8'h05, "R1 offset 3-bit readback");
    expect_reg(8'h30, 8'h00, "R1 unmapped offset");

    // R2 write of three bytes
    fbase = nfr;
    wr(8'h1A, 8'h12); wr(8'h1B, 8'h34);
    wr(8'h20, 8'h11); wr(8'h21, 8'h22); wr(8'h22, 8'h33);
    wr(8'h1E, 8'h03);
    expect_reg(8'h1F, 8'h01, "R6 busy right after write launch");
    wait_idle();
    chk(nfr - fbase == 1, "R2 one write frame", nfr - fbase, 1);
    expq = {8'h61, 8'h12, 8'h34, 8'h11, 8'h22, 8'h33};
    chk_frame(0, 6, "R2 write frame contents");
    expect_reg(8'h1F, 8'h00, "R6 idle no errors after write");

    // R7 count errors
    fbase = nfr;
    wr(8'h1E, 8'h09);
    expect_reg(8'h1F, 8'h08, "R7 write count 9");
    wr(8'h1D, 8'h00);
    expect_reg(8'h1F, 8'h08, "R7 read count 0");
    repeat (20) @(negedge clk);
    chk(nfr == fbase, "R7 no SPI frame on count error", nfr - fbase, 0);

    // R4 R5 read with three polls
    start_read(8'h05, 8'h07, 8'h00, 8'h04, 3);
    expect_reg(8'h1F, 8'h01, "R6 busy after read launch, R10 count error cleared");
    wait_idle();
    chk(nfr - fbase == 5, "R4 request + 3 polls + data frames", nfr - fbase, 5);
    expq = {8'h60, 8'h05, 8'h07};
    chk_frame(0, 3, "R4 request frame");
    expq = {8'h60, 8'hFE};
    chk_frame(3, 3, "R4 poll frame");
    expq = {8'h60, 8'hF0};
    chk_frame(4, 6, "R5 data frame length");
    expect_reg(8'h20, swmem(0), "R5 data0");
    expect_reg(8'h23, swmem(3), "R5 data3");
    expect_reg(8'h24, 8'h00, "R5 data4 untouched");
    expect_reg(8'h1F, 8'h00, "R6 read done no error");

    // R5 offset read
    start_read(8'h05, 8'h08, 8'h02, 8'h02, 1);
    wait_idle();
    expq = {8'h60, 8'hF0};
    chk_frame(2, 6, "R5 offset data frame length");
    expect_reg(8'h20, swmem(2), "R5 offset data0");
    expect_reg(8'h21, swmem(3), "R5 offset data1");

    // R5 longest read, bytes past register width kept as received
    start_read(8'h01, 8'h02, 8'h07, 8'h08, 1);
    wait_idle();
    chk_frame(2, 17, "R5 longest data frame");
    expect_reg(8'h20, swmem(7), "R5 long data0");
    expect_reg(8'h27, swmem(14), "R5 long data7");

    // R8 acknowledge error after 16 polls
    start_read(8'h02, 8'h03, 8'h00, 8'h01, 1000);
    wait_idle();
    chk(nfr - fbase == 17, "R8 request + 16 polls only", nfr - fbase, 17);
    expect_reg(8'h1F, 8'h04, "R8 ack error flag");
    // R10 sticky through other accesses
    wr(8'h1A, 8'h33);
    expect_reg(8'h1F, 8'h04, "R10 ack error held over page write");
    fbase = nfr;
    wr(8'h1E, 8'h01);
    expect_reg(8'h1F, 8'h01, "R10 errors cleared at launch");
    wait_idle();

    // R9 framing error
    frame_err = 1'b1;
    start_read(8'h02, 8'h03, 8'h00, 8'h02, 1);
    wait_idle();
    frame_err = 1'b0;
    chk(nfr - fbase == 2, "R9 read ends after bad poll", nfr - fbase, 2);
    expect_reg(8'h1F, 8'h02, "R9 framing error flag");

    // R11 writes ignored while busy
    start_read(8'h44, 8'h03, 8'h00, 8'h02, 5);
    wr(8'h1A, 8'h77); wr(8'h1E, 8'h02); wr(8'h1D, 8'h00);
    wait_idle();
    expect_reg(8'h1A, 8'h44, "R11 page unchanged");
    expect_reg(8'h1F, 8'h00, "R11 no count error from busy launch");
    seen_wr = 0;
    for (int f = fbase; f < nfr; f++) if (flog[f][0] == 8'h61) seen_wr = 1;
    chk(!seen_wr, "R11 no write frame while busy", seen_wr, 0);

    // R3 per-clock comparisons
    chk(mode_bad == 0, "R3 clock low with chip select high", mode_bad, 0);
    chk(gap_bad == 0, "R3 short chip select gap", gap_bad, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule